// File: doc/BRIEF.md
# BAR Sizing Sequencer

This block is a hardware walker that discovers how much address space each base address register of one configuration-space function decodes. A single start pulse, qualified by the function's header type, makes it visit every BAR slot that header type defines. For every implemented slot it captures the current contents, floods the register with ones, reads back which bits stuck, and puts the captured contents back, so the function is left exactly as it was found.

All register traffic goes through a simple request/acknowledge configuration port carrying a dword read or write, a byte offset and 32-bit data. Each access is held until acknowledged. Slot findings (whether the slot exists, its space type, whether it is half of a 64-bit pair, its prefetch bit and its decoded size) are offered one at a time on a valid/ready result port. A one-cycle completion pulse follows the last one. A 64-bit memory BAR is probed as a pair of dwords and reported once. Empty slots are reported as absent and the walk goes on to the next slot.

Top module: `bar_probe_seq`

## Requirements
- R1: Header type 0x00 makes the walk cover slots 0 to 5, 0x01 covers slots 0 and 1, and 0x02 covers slot 0 only. Any other header type produces the completion pulse with no result and no configuration access. Slot n lives at byte offset 0x10 + 4*n, and no access falls outside offsets 0x10 to 0x28.
- R2: Each implemented slot is probed in this order: a read of the original value, a write of 0xFFFFFFFF, a read-back, and a write of the original value. Every access keeps the request, offset, direction and data steady until an acknowledge arrives.
- R3: A slot whose original value has bit 0 = 0 and bits [2:1] = 2'b10 is a 64-bit pair. Its upper dword at offset +4 is read, flooded, read back and restored along with the lower one. The result carries is_64 = 1, and the next slot visited is two further on.
- R4: A slot whose original bit 0 is 1 is I/O space. It is never treated as a pair, whatever bits [2:1] hold, and it reports io = 1 with the prefetch bit 0.
- R5: Size is the bitwise inverse of the read-back, with its flag bits cleared, plus one. A memory BAR has its low 4 bits cleared and an I/O BAR its low 2 bits. The sum is taken in 32 bits and zero-extended for a single slot, so a masked read-back of zero gives size 0. For a pair it is taken in 64 bits over {upper, lower}.
- R6: A slot whose original value is zero is reported with present = 0, size 0 and all flags 0. It receives no write, and the walk continues with the next slot.
- R7: The upper dword of a pair is always restored to its original value, whatever its read-back holds.
- R8: A result carries the slot index, present, io, is_64, and prefetch (original bit 3 of a memory BAR). It stays valid and unchanged until ready is sampled high, and no configuration access is made while it is pending.
- R9: Busy rises the cycle after an accepted start and falls after the one-cycle completion pulse. The pulse comes after the last result is taken. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| hdr_type_i | input | 8 | Header type of the probed function |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_req_o | output | 1 | Configuration access request |
| cfg_we_o | output | 1 | 1 = dword write, 0 = dword read |
| cfg_addr_o | output | 12 | Byte offset of the access |
| cfg_wdata_o | output | 32 | Write data |
| cfg_ack_i | input | 1 | Access completion |
| cfg_rdata_i | input | 32 | Read data, valid with acknowledge |
| res_valid_o | output | 1 | Slot result pending |
| res_ready_i | input | 1 | Consumer takes the result |
| res_slot_o | output | 3 | Slot index |
| res_present_o | output | 1 | Slot implemented |
| res_io_o | output | 1 | I/O space slot |
| res_64_o | output | 1 | 64-bit pair |
| res_pref_o | output | 1 | Prefetchable memory |
| res_size_o | output | 64 | Decoded size in bytes |

## Verification
The checker watches several rules on every cycle. Configuration requests hold steady until acknowledged and stay inside the BAR window. A pending result stays frozen and blocks configuration traffic. Absent and I/O results never carry pair or prefetch flags. The completion pulse lasts one cycle and leaves the block idle. The bench scenarios are needed for the rest, because that behaviour depends on the register contents behind the port. These cover slot coverage per header type, the decoded sizes including the 32-bit wrap and the above-4 GB pair, the skipping of empty slots, and the restoring of every probed dword (checked through the write counts and final contents of a register model). They also show that a start issued in mid-walk has no effect.

// File: rtl/bar_probe_pkg.sv
package bar_probe_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WO_LO,
    ST_WO_HI,
    ST_RB_LO,
    ST_RB_HI,
    ST_RS_LO,
    ST_RS_HI,
    ST_RESULT,
    ST_DONE
  } probe_state_e;

  // memory space with 64-bit locator
  function automatic logic is_mem64(input logic [3:0] low);
    return (low[0] == 1'b0) && (low[2:1] == 2'b10);
  endfunction
endpackage

// File: rtl/bar_hdr_decode.sv
module bar_hdr_decode #(
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned MAX_SLOTS = 6
) (
  input  logic [7:0]      hdr_i,
  output logic [SLOT_W:0] limit_o,
  output logic            ok_o
);
  localparam logic [SLOT_W:0] LIM_EP  = (SLOT_W+1)'(MAX_SLOTS);
  localparam logic [SLOT_W:0] LIM_P2P = (SLOT_W+1)'(2);
  localparam logic [SLOT_W:0] LIM_CB  = (SLOT_W+1)'(1);

  always_comb begin
    ok_o    = 1'b1;
    limit_o = '0;
    unique case (hdr_i)
      8'h00:   limit_o = LIM_EP;
      8'h01:   limit_o = LIM_P2P;
      8'h02:   limit_o = LIM_CB;
      default: ok_o    = 1'b0;
    endcase
  end
endmodule

// File: rtl/bar_size_calc.sv
module bar_size_calc
  import bar_probe_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [3:0]     flags_i,   // low bits of original value
  input  logic [W-1:0]   rb_lo_i,
  input  logic [W-1:0]   rb_hi_i,
  output logic           io_o,
  output logic           pair_o,
  output logic           pref_o,
  output logic [2*W-1:0] size_o
);
  localparam int unsigned IO_FLAGS  = 2;
  localparam int unsigned MEM_FLAGS = 4;
  localparam logic [W-1:0] IO_MASK  = ~W'((1 << IO_FLAGS) - 1);
  localparam logic [W-1:0] MEM_MASK = ~W'((1 << MEM_FLAGS) - 1);

  logic [W-1:0]   masked_lo;
  logic [W-1:0]   size32;
  logic [2*W-1:0] size64;

  assign io_o      = flags_i[0];
  assign pair_o    = is_mem64(flags_i);
  assign pref_o    = !flags_i[0] && flags_i[3];
  assign masked_lo = rb_lo_i & (io_o ? IO_MASK : MEM_MASK);
  assign size32    = ~masked_lo + W'(1);
  assign size64    = ~{rb_hi_i, masked_lo} + (2*W)'(1);
  assign size_o    = pair_o ? size64 : {{W{1'b0}}, size32};
endmodule

// File: rtl/bar_probe_seq.sv
module bar_probe_seq
  import bar_probe_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned MAX_SLOTS = 6,
  parameter int unsigned BAR_BASE  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [7:0]          hdr_type_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                cfg_req_o,
  output logic                cfg_we_o,
  output logic [ADDR_W-1:0]   cfg_addr_o,
  output logic [DW-1:0]       cfg_wdata_o,
  input  logic                cfg_ack_i,
  input  logic [DW-1:0]       cfg_rdata_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [SLOT_W-1:0]   res_slot_o,
  output logic                res_present_o,
  output logic                res_io_o,
  output logic                res_64_o,
  output logic                res_pref_o,
  output logic [2*DW-1:0]     res_size_o
);
  localparam int unsigned     SIZE_W = 2*DW;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BAR_BASE);
  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(4);

  probe_state_e      state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W:0]   limit_q;
  logic [DW-1:0]     orig_lo_q, orig_hi_q, rb_lo_q, rb_hi_q;
  logic              absent_q;

  logic [SLOT_W:0]   hdr_limit;
  logic              hdr_ok;
  logic              calc_io, calc_pair, calc_pref;
  logic [SIZE_W-1:0] calc_size;
  logic [SLOT_W:0]   slot_next;
  logic              hi_sel;

  bar_hdr_decode #(
    .SLOT_W   (SLOT_W),
    .MAX_SLOTS(MAX_SLOTS)
  ) i_hdr_decode (
    .hdr_i  (hdr_type_i),
    .limit_o(hdr_limit),
    .ok_o   (hdr_ok)
  );

  bar_size_calc #(
    .W(DW)
  ) i_size_calc (
    .flags_i(orig_lo_q[3:0]),
    .rb_lo_i(rb_lo_q),
    .rb_hi_i(rb_hi_q),
    .io_o   (calc_io),
    .pair_o (calc_pair),
    .pref_o (calc_pref),
    .size_o (calc_size)
  );

  assign slot_next = {1'b0, slot_q} + (calc_pair ? (SLOT_W+1)'(2) : (SLOT_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      slot_q    <= '0;
      limit_q   <= '0;
      orig_lo_q <= '0;
      orig_hi_q <= '0;
      rb_lo_q   <= '0;
      rb_hi_q   <= '0;
      absent_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          slot_q  <= '0;
          limit_q <= hdr_limit;
          state_q <= hdr_ok ? ST_RD_LO : ST_DONE;
        end
        ST_RD_LO: if (cfg_ack_i) begin
          orig_lo_q <= cfg_rdata_i;
          orig_hi_q <= '0;
          rb_hi_q   <= '0;
          absent_q  <= (cfg_rdata_i == '0);
          if (cfg_rdata_i == '0)              state_q <= ST_RESULT;
          else if (is_mem64(cfg_rdata_i[3:0])) state_q <= ST_RD_HI;
          else                                 state_q <= ST_WO_LO;
        end
        ST_RD_HI: if (cfg_ack_i) begin
          orig_hi_q <= cfg_rdata_i;
          state_q   <= ST_WO_LO;
        end
        ST_WO_LO: if (cfg_ack_i) state_q <= calc_pair ? ST_WO_HI : ST_RB_LO;
        ST_WO_HI: if (cfg_ack_i) state_q <= ST_RB_LO;
        ST_RB_LO: if (cfg_ack_i) begin
          rb_lo_q <= cfg_rdata_i;
          state_q <= calc_pair ? ST_RB_HI : ST_RS_LO;
        end
        ST_RB_HI: if (cfg_ack_i) begin
          rb_hi_q <= cfg_rdata_i;
          state_q <= ST_RS_LO;
        end
        // upper restore keyed on original type bits only
        ST_RS_LO: if (cfg_ack_i) state_q <= calc_pair ? ST_RS_HI : ST_RESULT;
        ST_RS_HI: if (cfg_ack_i) state_q <= ST_RESULT;
        ST_RESULT: if (res_ready_i) begin
          if (slot_next >= limit_q) begin
            state_q <= ST_DONE;
          end else begin
            slot_q  <= slot_next[SLOT_W-1:0];
            state_q <= ST_RD_LO;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // configuration port
  always_comb begin
    cfg_req_o   = 1'b0;
    cfg_we_o    = 1'b0;
    cfg_wdata_o = '0;
    hi_sel      = 1'b0;
    unique case (state_q)
      ST_RD_LO, ST_RB_LO: cfg_req_o = 1'b1;
      ST_RD_HI, ST_RB_HI: begin cfg_req_o = 1'b1; hi_sel = 1'b1; end
      ST_WO_LO: begin cfg_req_o = 1'b1; cfg_we_o = 1'b1; cfg_wdata_o = '1; end
      ST_WO_HI: begin cfg_req_o = 1'b1; cfg_we_o = 1'b1; cfg_wdata_o = '1; hi_sel = 1'b1; end
      ST_RS_LO: begin cfg_req_o = 1'b1; cfg_we_o = 1'b1; cfg_wdata_o = orig_lo_q; end
      ST_RS_HI: begin cfg_req_o = 1'b1; cfg_we_o = 1'b1; cfg_wdata_o = orig_hi_q; hi_sel = 1'b1; end
      default: ;
    endcase
  end

  assign cfg_addr_o = BASE_A + ADDR_W'({slot_q, 2'b00}) + (hi_sel ? HI_OFS : '0);

  // result port
  assign res_valid_o   = (state_q == ST_RESULT);
  assign res_slot_o    = slot_q;
  assign res_present_o = !absent_q;
  assign res_io_o      = !absent_q && calc_io;
  assign res_64_o      = !absent_q && calc_pair;
  assign res_pref_o    = !absent_q && calc_pref;
  assign res_size_o    = absent_q ? '0 : calc_size;

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/bar_probe_chk.sv
module bar_probe_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned MAX_SLOTS = 6,
  parameter int unsigned BAR_BASE  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              cfg_req_o,
  input logic              cfg_we_o,
  input logic [ADDR_W-1:0] cfg_addr_o,
  input logic [31:0]       cfg_wdata_o,
  input logic              cfg_ack_i,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [SLOT_W-1:0] res_slot_o,
  input logic              res_present_o,
  input logic              res_io_o,
  input logic              res_64_o,
  input logic              res_pref_o,
  input logic [63:0]       res_size_o
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BAR_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BAR_BASE + 4*MAX_SLOTS);

  p_addr_win_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_addr_o >= LO_A) && (cfg_addr_o <= HI_A) && (cfg_addr_o[1:0] == 2'b00));

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_addr_o) && $stable(cfg_we_o)
                               && $stable(cfg_wdata_o));

  p_io_not64_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_io_o |-> !res_64_o && !res_pref_o);

  p_absent_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_present_o |-> (res_size_o == 64'd0) && !res_io_o && !res_64_o && !res_pref_o);

  p_res_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_slot_o) && $stable(res_size_o)
      && $stable(res_present_o) && $stable(res_io_o) && $stable(res_64_o) && $stable(res_pref_o));

  p_no_cfg_res_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !cfg_req_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cfg_req_o && !res_valid_o && !done_o);
endmodule

bind bar_probe_seq bar_probe_chk #(
  .ADDR_W   (ADDR_W),
  .SLOT_W   (SLOT_W),
  .MAX_SLOTS(MAX_SLOTS),
  .BAR_BASE (BAR_BASE)
) i_bar_probe_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .cfg_req_o    (cfg_req_o),
  .cfg_we_o     (cfg_we_o),
  .cfg_addr_o   (cfg_addr_o),
  .cfg_wdata_o  (cfg_wdata_o),
  .cfg_ack_i    (cfg_ack_i),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i),
  .res_slot_o   (res_slot_o),
  .res_present_o(res_present_o),
  .res_io_o     (res_io_o),
  .res_64_o     (res_64_o),
  .res_pref_o   (res_pref_o),
  .res_size_o   (res_size_o)
);

// File: tb/test_bar_probe_seq.sv
module test_bar_probe_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  hdr = 8'h00;
  logic        busy, done;
  logic        req, we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        ack = 1'b0;
  logic [31:0] rdata = '0;
  logic        rvalid;
  logic        ready = 1'b0;
  logic [2:0]  rslot;
  logic        rpres, rio, r64, rpref;
  logic [63:0] rsize;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bar_probe_seq i_bar_probe_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hdr_type_i(hdr),
    .busy_o(busy), .done_o(done),
    .cfg_req_o(req), .cfg_we_o(we), .cfg_addr_o(addr), .cfg_wdata_o(wdata),
    .cfg_ack_i(ack), .cfg_rdata_i(rdata),
    .res_valid_o(rvalid), .res_ready_i(ready), .res_slot_o(rslot),
    .res_present_o(rpres), .res_io_o(rio), .res_64_o(r64), .res_pref_o(rpref),
    .res_size_o(rsize)
  );

  // register model: dwords at 0x10..0x2C
  logic [31:0] init_val [8];
  logic [31:0] wmask    [8];
  logic [31:0] ro_bits  [8];
  logic [31:0] reg_val  [8];
  int          wr_cnt   [8];
  int          bad_acc = 0;
  logic        load = 1'b0;

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 8; i++) begin
        reg_val[i] <= init_val[i];
        wr_cnt[i]  <= 0;
      end
      bad_acc <= 0;
      ack     <= 1'b0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (addr < 12'h10 || addr > 12'h2C || addr[1:0] != 2'b00) begin
        bad_acc <= bad_acc + 1;
        rdata   <= '0;
      end else if (we) begin
        reg_val[(addr-12'h10)>>2] <= (wdata & wmask[(addr-12'h10)>>2]) | ro_bits[(addr-12'h10)>>2];
        wr_cnt[(addr-12'h10)>>2]  <= wr_cnt[(addr-12'h10)>>2] + 1;
      end else begin
        rdata <= reg_val[(addr-12'h10)>>2];
      end
    end else begin
      ack <= 1'b0;
    end
  end

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=finished)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input logic ok, input string req_tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic setup(input int k, input logic [31:0] v, input logic [31:0] m, input logic [31:0] r);
    init_val[k] = v;
    wmask[k]    = m;
    ro_bits[k]  = r;
  endtask

  task automatic clear_model();
    for (int i = 0; i < 8; i++) setup(i, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic load_model();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic kick(input logic [7:0] h);
    hdr   = h;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic take(input logic [2:0] slot, input logic pres, input logic io, input logic p64,
                      input logic pref, input logic [63:0] size, input string req_tag);
    int n = 0;
    while (!rvalid && n < 400) begin @(negedge clk); n++; end
    chk(rvalid, req_tag, "result valid", {63'd0, rvalid}, 64'd1);
    chk(rslot == slot, req_tag, "slot", {61'd0, rslot}, {61'd0, slot});
    chk(rpres == pres, req_tag, "present", {63'd0, rpres}, {63'd0, pres});
    chk(rio == io, req_tag, "io", {63'd0, rio}, {63'd0, io});
    chk(r64 == p64, req_tag, "is_64", {63'd0, r64}, {63'd0, p64});
    chk(rpref == pref, req_tag, "pref", {63'd0, rpref}, {63'd0, pref});
    chk(rsize == size, req_tag, "size", rsize, size);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic wait_done(input string req_tag);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done, req_tag, "completion pulse", {63'd0, done}, 64'd1);
    @(negedge clk);
    chk(!busy && !done, req_tag, "idle after pulse", {62'd0, busy, done}, 64'd0);
  endtask

  task automatic check_model(input int k, input int writes, input string req_tag);
    chk(reg_val[k] == init_val[k], req_tag, $sformatf("restored dword %0d", k), {32'd0, reg_val[k]}, {32'd0, init_val[k]});
    chk(wr_cnt[k] == writes, req_tag, $sformatf("write count dword %0d", k), 64'(wr_cnt[k]), 64'(writes));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !req && !rvalid, "R9", "reset outputs",
        {60'd0, busy, done, req, rvalid}, 64'd0);
  endtask

  // R1 R3 R4 R5 R6 R7: header 0 mix
  task automatic t_type0_mix();
    clear_model();
    setup(0, 32'hFEB0_0000, 32'hFFFF_F000, 32'h0);       // mem32 4 KB
    setup(2, 32'hFE00_000C, 32'hFFF0_0000, 32'h0000_000C); // 64-bit pref 1 MB
    setup(3, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0);       // its upper half
    setup(4, 32'h0000_E105, 32'hFFFF_FFFC, 32'h0000_0001); // I/O, bits[2:1]=10
    setup(5, 32'hFEC0_0008, 32'hFFFF_FFF0, 32'h0000_0008); // pref 16 B
    load_model();
    kick(8'h00);
    take(3'd0, 1, 0, 0, 0, 64'h1000, "R5");
    take(3'd1, 0, 0, 0, 0, 64'h0, "R6");
    take(3'd2, 1, 0, 1, 1, 64'h10_0000, "R3");
    take(3'd4, 1, 1, 0, 0, 64'h4, "R4");
    take(3'd5, 1, 0, 0, 1, 64'h10, "R5");
    wait_done("R1");
    check_model(0, 2, "R2");
    check_model(1, 0, "R6");
    check_model(2, 2, "R3");
    check_model(3, 2, "R7");
    check_model(4, 2, "R4");
    check_model(5, 2, "R2");
    chk(bad_acc == 0, "R1", "out-of-window accesses", 64'(bad_acc), 64'd0);
  endtask

  // R1 R5: header 1, 32-bit wrap and I/O
  task automatic t_type1();
    clear_model();
    setup(0, 32'h0000_0008, 32'h0, 32'h0000_0008);        // readback masks to zero
    setup(1, 32'h0000_C001, 32'hFFFF_FF00, 32'h0000_0001); // I/O 256 B
    setup(2, 32'hFD00_0000, 32'hFFFF_FF00, 32'h0);        // outside header 1 range
    load_model();
    kick(8'h01);
    take(3'd0, 1, 0, 0, 1, 64'h0, "R5");
    take(3'd1, 1, 1, 0, 0, 64'h100, "R5");
    wait_done("R1");
    check_model(0, 2, "R2");
    check_model(1, 2, "R2");
    check_model(2, 0, "R1");
  endtask

  // R3 R6 R7: pair above 4 GB then empty slots
  task automatic t_big_pair();
    clear_model();
    setup(0, 32'h0000_000C, 32'h0, 32'h0000_000C);
    setup(1, 32'h0000_0020, 32'hFFFF_FFF0, 32'h0);
    load_model();
    kick(8'h00);
    take(3'd0, 1, 0, 1, 1, 64'h10_0000_0000, "R3");
    take(3'd2, 0, 0, 0, 0, 64'h0, "R6");
    take(3'd3, 0, 0, 0, 0, 64'h0, "R6");
    take(3'd4, 0, 0, 0, 0, 64'h0, "R6");
    take(3'd5, 0, 0, 0, 0, 64'h0, "R6");
    wait_done("R6");
    check_model(0, 2, "R3");
    check_model(1, 2, "R7");
  endtask

  // R1: unsupported header
  task automatic t_bad_hdr();
    clear_model();
    setup(0, 32'hFD00_0000, 32'hFFFF_FF00, 32'h0);
    load_model();
    kick(8'h7F);
    chk(!rvalid, "R1", "no result for bad header", {63'd0, rvalid}, 64'd0);
    wait_done("R1");
    check_model(0, 0, "R1");
    chk(bad_acc == 0, "R1", "no access", 64'(bad_acc), 64'd0);
  endtask

  // R8 R9: back-pressure and start while busy
  task automatic t_hold_and_restart();
    int n = 0;
    logic held_ok = 1'b1;
    clear_model();
    setup(0, 32'hFD00_0000, 32'hFFFF_FF00, 32'h0);
    setup(1, 32'hFC00_0000, 32'hFFFF_F000, 32'h0);
    load_model();
    kick(8'h02);
    @(negedge clk);
    chk(busy, "R9", "busy after start", {63'd0, busy}, 64'd1);
    kick(8'h00);
    while (!rvalid && n < 400) begin @(negedge clk); n++; end
    for (int i = 0; i < 12; i++) begin
      if (!rvalid || req || rsize != 64'h100 || rslot != 3'd0) held_ok = 1'b0;
      @(negedge clk);
    end
    chk(held_ok, "R8", "result held with no traffic", {63'd0, held_ok}, 64'd1);
    take(3'd0, 1, 0, 0, 0, 64'h100, "R8");
    wait_done("R9");
    held_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (busy || rvalid || req) held_ok = 1'b0;
      @(negedge clk);
    end
    chk(held_ok, "R9", "mid-walk start ignored", {63'd0, held_ok}, 64'd1);
    check_model(1, 0, "R9");
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type0_mix();
    t_type1();
    t_big_pair();
    t_bad_hdr();
    t_hold_and_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule